// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

This block is a memory-mapped event timer. One 64-bit main counter runs off the block clock. Several comparator channels watch that counter, and each channel can raise its own interrupt line. Software uses a plain 32-bit read/write bus to read the capability words, start and stop the counter, load comparators and clear pending level interrupts.

Each channel can run in one-shot mode or, if it is built as periodic-capable, in periodic mode. A periodic channel has a hidden accumulator that holds the next match time, plus a period register. On every match the period is added to the accumulator, so the channel fires again with no software action. An armed set-value bit sends the first comparator write to the accumulator and later writes to the period. A channel signals either as a one-cycle edge pulse or as a level that stays high until software clears it. A channel can also be told to compare only the low 32 bits of the counter.

Reads return data combinationally in the cycle in which the address is presented. A match is detected when the counter steps onto the comparator value. The interrupt becomes visible in the cycle in which the counter reads that value.

Top module: `ev_timer`

## Requirements
- R1: Capability word at 0x000 holds the channel count minus one in bits [4:0] and a 1 in bit 8, which reports a 64-bit counter. The word at 0x004 holds the counter tick period in femtoseconds. Both words are read-only.
- R2: The main counter increases by one per clock only while bit 0 of the global configuration word at 0x010 is 1. Otherwise it holds its value. After reset the counter and the enable bit are 0.
- R3: The counter's low word is at 0x030 and its high word at 0x034. Writing either word replaces that half. A write takes precedence over the increment in that cycle.
- R4: Channel n has its registers at 0x100 + 0x20·n: configuration at +0x0, comparator low word at +0x8, comparator high word at +0xC. A high-word write is staged. A low-word write commits the staged high word together with the written low word. Reading the comparator words returns the accumulator.
- R5: A channel matches when an increment moves the counter onto the accumulator value. A one-shot channel therefore fires once per pass of the counter over that value.
- R6: With configuration bit 0 (level) clear and bit 1 (enable) set, a match gives a single-cycle pulse on irq[n], in the cycle in which the counter reads the match value. The status bit is not touched.
- R7: With bit 0 set, a match sets bit n of the status word at 0x020, whatever the enable bit holds. irq[n] is status & enable. Writing 1 to a status bit clears it, and writing 0 changes nothing. A match in the same cycle wins over the clear.
- R8: On a periodic channel, writing configuration bit 4 (set-value) as 1 sends the next comparator low-word write to the accumulator. That write clears bit 4 by itself. Low-word writes after it load only the period.
- R9: On each match of a periodic channel, the period is added to the accumulator, unless a comparator low-word write happens in the same cycle.
- R10: Bit 3 of a channel configuration is read-only and reports whether the channel is periodic-capable (parameter mask, default channels 0 and 1). On a channel that is not capable, a write to bit 2 (periodic) is ignored, so the bit reads 0 and the channel runs as one-shot.
- R11: With configuration bit 5 set, the match compares only the low 32 bits of the counter and of the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the counter ticks on it |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| irq | output | NCH | One interrupt line per channel |

## Verification
The hardest case to reach is a periodic channel that has to show its reload several times, while a one-shot level channel and a 32-bit-mode channel share the same run of the counter. From reset, this needs the counter preset just below a 32-bit carry, the two-write periodic load done in the right order, and status clears placed between periodic matches. The bench presets the counter to 0xFFFF_FFF8 before enabling it. That carries the count into the high word within a few cycles, so the 64-bit comparators and the 32-bit masked compare can be told apart. It then clears the status at intervals shorter than the period and compares every interrupt line, every clock, with its behavioural model.

// File: rtl/ev_timer_pkg.sv
package ev_timer_pkg;

    localparam int CNT_W  = 64;
    localparam int WORD_W = 32;

    localparam logic [11:0] A_CAP0   = 12'h000;
    localparam logic [11:0] A_CAP1   = 12'h004;
    localparam logic [11:0] A_GCFG   = 12'h010;
    localparam logic [11:0] A_STS    = 12'h020;
    localparam logic [11:0] A_CNT_LO = 12'h030;
    localparam logic [11:0] A_CNT_HI = 12'h034;

    localparam logic [3:0] CH_PAGE    = 4'h1;
    localparam logic [2:0] OFF_CFG    = 3'd0;
    localparam logic [2:0] OFF_CMP_LO = 3'd2;
    localparam logic [2:0] OFF_CMP_HI = 3'd3;

    typedef struct packed {
        logic f32;
        logic setval;
        logic per;
        logic ie;
        logic level;
    } ch_cfg_t;

    function automatic logic [WORD_W-1:0] cfg_to_word(ch_cfg_t c, logic cap);
        return {26'd0, c.f32, c.setval, cap, c.per, c.ie, c.level};
    endfunction

    function automatic ch_cfg_t word_to_cfg(logic [WORD_W-1:0] w, logic cap);
        ch_cfg_t c;
        c.level  = w[0];
        c.ie     = w[1];
        c.per    = w[2] & cap;
        c.setval = w[4];
        c.f32    = w[5];
        return c;
    endfunction

endpackage

// File: rtl/ev_counter.sv
module ev_counter
    import ev_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_nxt,
    output logic              tick
);
    assign tick    = en & ~wr_lo & ~wr_hi;
    assign cnt_nxt = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
        end else begin
            if (wr_lo) cnt_q[WORD_W-1:0]     <= wdata;
            if (wr_hi) cnt_q[CNT_W-1:WORD_W] <= wdata;
        end
    end
endmodule

// File: rtl/ev_channel.sv
module ev_channel
    import ev_timer_pkg::*;
#(
    parameter bit PER_CAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [CNT_W-1:0]  cnt_nxt,
    input  logic              wr_cfg,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic              sts_clr,
    output logic [WORD_W-1:0] cfg_word,
    output logic [CNT_W-1:0]  acc_q,
    output logic [CNT_W-1:0]  per_q,
    output logic              status_q,
    output logic              level,
    output logic              irq,
    output logic              hit,
    output logic              per_eff
);
    ch_cfg_t           cfg_q;
    logic [WORD_W-1:0] stage_q;
    logic              pulse_q;
    logic              match;

    assign per_eff  = cfg_q.per;
    assign level    = cfg_q.level;
    assign cfg_word = cfg_to_word(cfg_q, PER_CAP);

    assign match = cfg_q.f32 ? (cnt_nxt[WORD_W-1:0] == acc_q[WORD_W-1:0])
                             : (cnt_nxt == acc_q);
    assign hit   = tick & match;
    assign irq   = cfg_q.level ? (status_q & cfg_q.ie) : pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            stage_q  <= '0;
            acc_q    <= '0;
            per_q    <= '0;
            status_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            pulse_q <= hit & cfg_q.ie & ~cfg_q.level;

            if (hit & cfg_q.level)  status_q <= 1'b1;
            else if (sts_clr)       status_q <= 1'b0;

            if (wr_cfg) cfg_q   <= word_to_cfg(wdata, PER_CAP);
            if (wr_hi)  stage_q <= wdata;

            if (wr_lo) begin
                if (per_eff && !cfg_q.setval) begin
                    per_q <= {stage_q, wdata};
                end else begin
                    acc_q        <= {stage_q, wdata};
                    cfg_q.setval <= 1'b0;
                end
            end else if (hit && per_eff) begin
                acc_q <= acc_q + per_q;
            end
        end
    end
endmodule

// File: rtl/ev_timer.sv
module ev_timer
    import ev_timer_pkg::*;
#(
    parameter int          NCH          = 3,
    parameter logic [31:0] PERIOD_FS    = 32'd69841279,
    parameter logic [7:0]  PER_CAP_MASK = 8'h03
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [NCH-1:0] irq
);
    localparam logic [4:0] NCH_M1 = 5'(NCH - 1);

    logic                          gen_en_q;
    logic [CNT_W-1:0]              cnt_q;
    logic [CNT_W-1:0]              cnt_nxt;
    logic                          tick;
    logic                          wr_cnt_lo, wr_cnt_hi, cnt_wr_any, sts_wr;
    logic                          ch_page;
    logic [2:0]                    ch_sel;
    logic [2:0]                    ch_off;
    logic [NCH-1:0][WORD_W-1:0]    cfg_w;
    logic [NCH-1:0][CNT_W-1:0]     acc_w;
    logic [NCH-1:0][CNT_W-1:0]     per_w;
    logic [NCH-1:0]                status_v, hit_v, per_eff_v, lvl_v, cmp_lo_wr_v;

    assign wr_cnt_lo  = bus_wr && (bus_addr == A_CNT_LO);
    assign wr_cnt_hi  = bus_wr && (bus_addr == A_CNT_HI);
    assign cnt_wr_any = wr_cnt_lo | wr_cnt_hi;
    assign sts_wr     = bus_wr && (bus_addr == A_STS);
    assign ch_page    = (bus_addr[11:8] == CH_PAGE);
    assign ch_sel     = bus_addr[7:5];
    assign ch_off     = bus_addr[4:2];

    always_ff @(posedge clk) begin
        if (rst)                                   gen_en_q <= 1'b0;
        else if (bus_wr && bus_addr == A_GCFG)     gen_en_q <= bus_wdata[0];
    end

    ev_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en      (gen_en_q),
        .wr_lo   (wr_cnt_lo),
        .wr_hi   (wr_cnt_hi),
        .wdata   (bus_wdata),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .tick    (tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel_i;
        assign sel_i          = bus_wr && ch_page && (ch_sel == 3'(i));
        assign cmp_lo_wr_v[i] = sel_i && (ch_off == OFF_CMP_LO);

        ev_channel #(.PER_CAP(PER_CAP_MASK[i])) u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .cnt_nxt  (cnt_nxt),
            .wr_cfg   (sel_i && (ch_off == OFF_CFG)),
            .wr_lo    (cmp_lo_wr_v[i]),
            .wr_hi    (sel_i && (ch_off == OFF_CMP_HI)),
            .wdata    (bus_wdata),
            .sts_clr  (sts_wr && bus_wdata[i]),
            .cfg_word (cfg_w[i]),
            .acc_q    (acc_w[i]),
            .per_q    (per_w[i]),
            .status_q (status_v[i]),
            .level    (lvl_v[i]),
            .irq      (irq[i]),
            .hit      (hit_v[i]),
            .per_eff  (per_eff_v[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CAP0:   bus_rdata = {23'd0, 1'b1, 3'd0, NCH_M1};
            A_CAP1:   bus_rdata = PERIOD_FS;
            A_GCFG:   bus_rdata = {31'd0, gen_en_q};
            A_STS:    bus_rdata = 32'(status_v);
            A_CNT_LO: bus_rdata = cnt_q[WORD_W-1:0];
            A_CNT_HI: bus_rdata = cnt_q[CNT_W-1:WORD_W];
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (ch_page && ch_sel == 3'(i)) begin
                        case (ch_off)
                            OFF_CFG:    bus_rdata = cfg_w[i];
                            OFF_CMP_LO: bus_rdata = acc_w[i][WORD_W-1:0];
                            OFF_CMP_HI: bus_rdata = acc_w[i][CNT_W-1:WORD_W];
                            default:    bus_rdata = '0;
                        endcase
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/ev_timer_chk.sv
module ev_timer_chk #(
    parameter int NCH = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic                 cnt_wr,
    input logic [63:0]          cnt,
    input logic [NCH-1:0]       status,
    input logic                 sts_wr,
    input logic [31:0]          wdata,
    input logic [NCH-1:0]       hit,
    input logic [NCH-1:0]       lvl,
    input logic [NCH-1:0]       per_eff,
    input logic [NCH-1:0]       cmp_wr,
    input logic [NCH-1:0][63:0] acc,
    input logic [NCH-1:0][63:0] per
);
    // R2: counter holds while disabled and not written
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !en && !cnt_wr |=> $stable(cnt))
        else $error("a_r2_hold");

    // R2: counter steps by exactly one while enabled
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        en && !cnt_wr |=> cnt == $past(cnt) + 64'd1)
        else $error("a_r2_step");

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R7: a pending status bit survives unless a 1 is written to it
        a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
            status[i] && !(sts_wr && wdata[i]) |=> status[i])
            else $error("a_r7_sticky");

        // R7: a level-mode match always leaves status set
        a_r7_set: assert property (@(posedge clk) disable iff (rst)
            hit[i] && lvl[i] |=> status[i])
            else $error("a_r7_set");

        // R9: a periodic match advances the accumulator by one period
        a_r9_reload: assert property (@(posedge clk) disable iff (rst)
            hit[i] && per_eff[i] && !cmp_wr[i] |=> acc[i] == $past(acc[i]) + $past(per[i]))
            else $error("a_r9_reload");
    end
endmodule

bind ev_timer ev_timer_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (gen_en_q),
    .cnt_wr  (cnt_wr_any),
    .cnt     (cnt_q),
    .status  (status_v),
    .sts_wr  (sts_wr),
    .wdata   (bus_wdata),
    .hit     (hit_v),
    .lvl     (lvl_v),
    .per_eff (per_eff_v),
    .cmp_wr  (cmp_lo_wr_v),
    .acc     (acc_w),
    .per     (per_w)
);

// File: tb/ev_timer_bench.sv
module ev_timer_bench;
    localparam int          NCH = 3;
    localparam logic [31:0] PFS = 32'd69841279;
    localparam logic [2:0]  CAP = 3'b011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] irq;

    ev_timer u_ev_timer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    string phase = "R1";

    // behavioural reference model
    logic [63:0] m_cnt;
    logic        m_en;
    logic [63:0] m_acc [NCH];
    logic [63:0] m_per [NCH];
    logic [31:0] m_stg [NCH];
    logic        m_lvl [NCH], m_ie [NCH], m_pm [NCH], m_sv [NCH], m_f32 [NCH];
    logic        m_sts [NCH], m_pls [NCH];

    always @(posedge clk) begin
        logic        tk, h, lo_w;
        logic [63:0] nx;
        if (rst) begin
            m_cnt = '0; m_en = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                m_acc[c] = '0; m_per[c] = '0; m_stg[c] = '0;
                m_lvl[c] = 0; m_ie[c] = 0; m_pm[c] = 0; m_sv[c] = 0; m_f32[c] = 0;
                m_sts[c] = 0; m_pls[c] = 0;
            end
        end else begin
            tk = m_en && !(bus_wr && (bus_addr == 12'h030 || bus_addr == 12'h034));
            nx = m_cnt + 64'd1;
            for (int c = 0; c < NCH; c++) begin
                h = tk && (m_f32[c] ? (nx[31:0] == m_acc[c][31:0]) : (nx == m_acc[c]));
                lo_w = bus_wr && bus_addr == 12'(32'h108 + 32 * c);
                m_pls[c] = h && m_ie[c] && !m_lvl[c];
                if (h && m_lvl[c]) m_sts[c] = 1'b1;
                else if (bus_wr && bus_addr == 12'h020 && bus_wdata[c]) m_sts[c] = 1'b0;
                if (lo_w) begin
                    if (m_pm[c] && !m_sv[c]) m_per[c] = {m_stg[c], bus_wdata};
                    else begin m_acc[c] = {m_stg[c], bus_wdata}; m_sv[c] = 1'b0; end
                end else if (h && m_pm[c]) m_acc[c] = m_acc[c] + m_per[c];
                if (bus_wr && bus_addr == 12'(32'h10C + 32 * c)) m_stg[c] = bus_wdata;
                if (bus_wr && bus_addr == 12'(32'h100 + 32 * c)) begin
                    m_lvl[c] = bus_wdata[0]; m_ie[c] = bus_wdata[1];
                    m_pm[c]  = bus_wdata[2] & CAP[c];
                    m_sv[c]  = bus_wdata[4]; m_f32[c] = bus_wdata[5];
                end
            end
            if (tk) m_cnt = nx;
            else begin
                if (bus_wr && bus_addr == 12'h030) m_cnt[31:0]  = bus_wdata;
                if (bus_wr && bus_addr == 12'h034) m_cnt[63:32] = bus_wdata;
            end
            if (bus_wr && bus_addr == 12'h010) m_en = bus_wdata[0];
        end
    end

    function automatic logic [31:0] mread(logic [11:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            12'h000: r = 32'h0000_0100 | 32'(NCH - 1);
            12'h004: r = PFS;
            12'h010: r = {31'd0, m_en};
            12'h020: for (int c = 0; c < NCH; c++) r[c] = m_sts[c];
            12'h030: r = m_cnt[31:0];
            12'h034: r = m_cnt[63:32];
            default:
                for (int c = 0; c < NCH; c++) begin
                    if (a == 12'(32'h100 + 32 * c))
                        r = {26'd0, m_f32[c], m_sv[c], CAP[c], m_pm[c], m_ie[c], m_lvl[c]};
                    if (a == 12'(32'h108 + 32 * c)) r = m_acc[c][31:0];
                    if (a == 12'(32'h10C + 32 * c)) r = m_acc[c][63:32];
                end
        endcase
        return r;
    endfunction

    function automatic logic [NCH-1:0] mirq();
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) v[c] = m_lvl[c] ? (m_sts[c] & m_ie[c]) : m_pls[c];
        return v;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // interrupt lines compared with the model on every clock
    always @(negedge clk) if (!rst) chk({phase, " irq"}, 32'(irq), 32'(mirq()));

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #2 chk(tag, bus_rdata, mread(a));
    endtask

    task automatic rdx(logic [11:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #2 chk(tag, bus_rdata, e);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] cl, tgt, c1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        phase = "R1";
        rdx(12'h000, 32'h0000_0102, "R1 cap0");
        rdx(12'h004, PFS, "R1 cap1");
        phase = "R3";
        rdx(12'h030, 32'h0, "R3 reset cnt lo");
        rdx(12'h034, 32'h0, "R3 reset cnt hi");
        rdx(12'h020, 32'h0, "R7 reset status");
        phase = "R10";
        rdx(12'h100, 32'h0000_0008, "R10 ch0 capable");
        rdx(12'h140, 32'h0000_0000, "R10 ch2 not capable");

        phase = "R2";
        idle(5);
        rdx(12'h030, 32'h0, "R2 disabled hold");

        // ch0: one-shot edge at 0x1_00000004
        phase = "R6";
        wr(12'h100, 32'h2);
        wr(12'h10C, 32'h1);
        wr(12'h108, 32'h4);
        rd(12'h108, "R4 ch0 cmp lo");
        rdx(12'h10C, 32'h1, "R4 ch0 cmp hi");
        // ch1: periodic level, first at 0x1_00000008, period 5
        phase = "R8";
        wr(12'h120, 32'h17);
        wr(12'h12C, 32'h1);
        wr(12'h128, 32'h8);
        rdx(12'h120, 32'h0000_000F, "R8 setval self-cleared");
        wr(12'h12C, 32'h0);
        wr(12'h128, 32'h5);
        rdx(12'h128, 32'h8, "R8 period write leaves accumulator");
        // ch2: periodic request ignored, one-shot level at 0x1_0000000A
        phase = "R10";
        wr(12'h140, 32'h7);
        rdx(12'h140, 32'h3, "R10 periodic bit ignored");
        wr(12'h14C, 32'h1);
        wr(12'h148, 32'hA);

        phase = "R3";
        wr(12'h030, 32'hFFFF_FFF8);
        rd(12'h030, "R3 cnt lo write");
        phase = "R5 R6 R7 R9";
        wr(12'h010, 32'h1);
        idle(14);
        rdx(12'h034, 32'h1, "R3 carry into high word");
        rd(12'h020, "R7 status after level matches");
        wr(12'h020, 32'h0);
        rd(12'h020, "R7 zero write no effect");
        for (int k = 0; k < 6; k++) begin
            wr(12'h020, 32'h6);
            idle(2);
        end
        rd(12'h128, "R9 periodic accumulator advanced");
        rd(12'h020, "R7 status after clears");
        idle(30);
        rd(12'h020, "R5 one-shot ch2 silent after clear");

        // ch0 low-32-bit compare
        phase = "R11";
        wr(12'h100, 32'h22);
        wr(12'h10C, 32'h5);
        cl  = m_cnt[31:0];
        tgt = cl + 32'd20;
        wr(12'h108, tgt);
        idle(30);
        rd(12'h020, "R6 edge leaves status bit 0");
        rd(12'h108, "R11 accumulator kept");

        phase = "R2";
        wr(12'h010, 32'h0);
        c1 = m_cnt[31:0];
        rd(12'h030, "R2 stop");
        idle(6);
        rdx(12'h030, c1, "R2 hold after stop");
        wr(12'h034, 32'h7);
        rdx(12'h034, 32'h7, "R3 high word write");

        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule